// File: doc/BRIEF.md
# Indirect Serial Flash Read Engine

This block fetches a run of bytes from a serial flash device into an on-chip word FIFO. The host is not involved while the transfer runs. Software first programs a start address, a byte count, an instruction word and an optional mode byte. It then sets a start bit. The engine lowers chip select and sends the command header. The header is the opcode, then the address with the most significant byte first, then the mode byte if it is enabled, then a number of idle dummy cycles. The engine then collects the requested number of data bytes.

Received bytes are packed into 32-bit words and pushed into the FIFO. The host reads the FIFO fill level and drains words through a separate pop port. When the FIFO is full, the engine stops issuing data byte slots until space frees up, so no byte is lost. A status bit shows that a transfer is in progress. A sticky completion flag is set at the end and is cleared by writing 1 to it. A cancel request aborts the transfer, releases the flash and empties the FIFO.

The flash side is a byte-serial interface. In any cycle the engine may issue one byte slot: either a transmit slot that drives `flashTxByte`, or a receive slot that samples `flashRxByte` at the next rising clock edge.

Top module: `flash_read_engine`

## Requirements
- R1: After reset, chip select is high (inactive), no byte slot is issued, and the control register (index 0) and the level register (index 5) both read 0.
- R2: A transfer started by writing 1 to control bit 0 sends these transmit slots in this order: the opcode (instruction register bits 7:0), then the start address (register 1) most significant byte first. The address has 4 bytes when instruction bits 15:14 equal 3, and 3 bytes (address bits 23:0) otherwise. Every slot is issued with chip select low.
- R3: When instruction bit 8 is set, exactly one transmit slot carrying mode register (index 4) bits 7:0 follows the address. When the bit is clear, no such slot is sent.
- R4: After the last header byte, chip select stays low for exactly the number of cycles in instruction bits 13:9, with no slot issued. The first receive slot follows.
- R5: The engine issues exactly as many receive slots as the byte count (register 2). Bytes are packed little-endian: byte k of a word occupies bits 8k+7:8k.
- R6: If the count is not a multiple of four, the final word is pushed with its unused upper bytes set to zero.
- R7: Level register bits 15:0 give the number of 32-bit words held in the FIFO. Each pop of a non-empty FIFO removes the oldest word, and that word is shown on `popData` before the pop.
- R8: No receive slot is issued while the FIFO holds DEPTH words. Reception resumes after a pop, and no byte is lost.
- R9: Control bit 2 reads 1 while a transfer runs. A start request made while a transfer runs has no effect.
- R10: Control bit 5 becomes 1 when the last byte has been received. Chip select then returns high. The bit stays 1 until a write with bit 5 set, which clears it. A write with bit 5 clear leaves it set.
- R11: Writing 1 to control bit 1 ends any transfer at the next clock edge. Chip select goes high, the FIFO is emptied, control bits 2 and 5 clear, and a later transfer packs from byte lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index for both read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| popEn | input | 1 | Pops the head FIFO word at the clock edge |
| popData | output | 32 | Head FIFO word (zero when the FIFO is empty) |
| flashCsN | output | 1 | Flash chip select, active low |
| flashStrobe | output | 1 | A byte slot is issued this cycle |
| flashRead | output | 1 | The slot is a receive slot |
| flashTxByte | output | 8 | Byte sent in a transmit slot |
| flashRxByte | input | 8 | Byte received in a receive slot |

## Verification
A register write lands at the next rising edge. The first transmit slot of a header is therefore visible in the cycle after the start write. A cancel shows on chip select, on the status bits and on the level in the cycle after the cancel write. A word pushed on the edge that takes its last byte is counted in the level one edge later. The bench samples every output on the falling edge. It counts header bytes and dummy gaps slot by slot, as they appear, against queues filled by the driver. It compares drained words one at a time against words the bench computed from its own flash byte pattern. It checks the FIFO-full stall by counting the receive slots accepted once the FIFO has had time to fill.

// File: rtl/flash_read_pkg.sv
package flash_read_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_ADDR  = 3'd1;
  localparam logic [REG_AW-1:0] RA_COUNT = 3'd2;
  localparam logic [REG_AW-1:0] RA_INSTR = 3'd3;
  localparam logic [REG_AW-1:0] RA_MODE  = 3'd4;
  localparam logic [REG_AW-1:0] RA_LEVEL = 3'd5;

  localparam int CB_START  = 0;
  localparam int CB_CANCEL = 1;
  localparam int CB_BUSY   = 2;
  localparam int CB_DONE   = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_MODE,
    ST_DUMMY,
    ST_DATA
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic takeByte;
    logic lastByte;
    logic flush;
  } dpCtl_t;

endpackage

// File: rtl/flash_read_dp.sv
module flash_read_dp
  import flash_read_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           dpCtl,
  input  logic [7:0]       rxByte,
  input  logic             popEn,
  output logic [31:0]      popData,
  output logic [LVL_W-1:0] fifoLevel,
  output logic             fifoFull
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

  logic [31:0]      packReg;
  logic [1:0]       packIdx;
  logic [31:0]      mergedWord;
  logic             pushNow;
  logic             doPop;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [31:0]      mem [DEPTH];

  // place the incoming byte into its lane, little-endian
  assign mergedWord = packReg | ({24'h0, rxByte} << {packIdx, 3'b000});
  assign pushNow    = dpCtl.takeByte && (packIdx == 2'd3 || dpCtl.lastByte);
  assign doPop      = popEn && (fifoLevel != '0) && !dpCtl.flush;
  assign fifoFull   = (fifoLevel == DEPTH_L);
  assign popData    = (fifoLevel != '0) ? mem[rdPtr] : 32'h0;

  always_ff @(posedge clk) begin
    if (!rstN || dpCtl.flush) begin
      packReg <= '0;
      packIdx <= '0;
    end else if (dpCtl.takeByte) begin
      if (pushNow) begin
        packReg <= '0;
        packIdx <= '0;
      end else begin
        packReg <= mergedWord;
        packIdx <= packIdx + 2'd1;
      end
    end
  end

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : gEntry
      always_ff @(posedge clk) begin
        if (!rstN) begin
          mem[e] <= '0;
        end else if (pushNow && wrPtr == PTR_W'(e)) begin
          mem[e] <= mergedWord;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || dpCtl.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoLevel <= '0;
    end else begin
      if (pushNow) wrPtr <= (wrPtr == LAST_P) ? '0 : wrPtr + 1'b1;
      if (doPop)   rdPtr <= (rdPtr == LAST_P) ? '0 : rdPtr + 1'b1;
      case ({pushNow, doPop})
        2'b10:   fifoLevel <= fifoLevel + 1'b1;
        2'b01:   fifoLevel <= fifoLevel - 1'b1;
        default: fifoLevel <= fifoLevel;
      endcase
    end
  end

endmodule

// File: rtl/flash_read_ctrl.sv
module flash_read_ctrl
  import flash_read_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LVL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              fifoFull,
  input  logic [LVL_W-1:0]  fifoLevel,
  output dpCtl_t            dpCtl,
  output logic              flashCsN,
  output logic              flashStrobe,
  output logic              flashRead,
  output logic [7:0]        flashTxByte,
  output logic              doneFlag,
  output logic              busyFlag
);

  // configuration
  logic [31:0]      startAddr;
  logic [CNT_W-1:0] byteCnt;
  logic [7:0]       opcode;
  logic             modeEn;
  logic [4:0]       dummyCfg;
  logic [1:0]       addrCode;
  logic [7:0]       modeByte;

  // sequencing state
  seqState_t        state, stateNext;
  logic [31:0]      addrShift;
  logic [1:0]       addrLeft;
  logic [4:0]       dummyLeft;
  logic [CNT_W-1:0] remain;
  logic             finishNow;
  logic             done;

  logic wrCtrl, startReq, cancelReq, addr4, dataSlot;
  seqState_t postHeader;

  assign wrCtrl    = regWrEn && (regAddr == RA_CTRL);
  assign cancelReq = wrCtrl && regWrData[CB_CANCEL];
  assign startReq  = wrCtrl && regWrData[CB_START] && !cancelReq && (state == ST_IDLE);
  assign addr4     = (addrCode == 2'd3);
  assign dataSlot  = (state == ST_DATA) && !fifoFull;

  // state after the last header byte (address or mode byte)
  always_comb begin
    if (dummyLeft != '0)   postHeader = ST_DUMMY;
    else if (remain != '0) postHeader = ST_DATA;
    else                   postHeader = ST_IDLE;
  end

  always_comb begin
    stateNext = state;
    finishNow = 1'b0;
    unique case (state)
      ST_IDLE:  if (startReq) stateNext = ST_OPC;
      ST_OPC:   stateNext = ST_ADDR;
      ST_ADDR:  if (addrLeft == '0) stateNext = modeEn ? ST_MODE : postHeader;
      ST_MODE:  stateNext = postHeader;
      ST_DUMMY: if (dummyLeft == 5'd1) stateNext = (remain != '0) ? ST_DATA : ST_IDLE;
      ST_DATA:  if (dataSlot && remain == CNT_W'(1)) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
    if (state != ST_IDLE && stateNext == ST_IDLE) finishNow = 1'b1;
    if (cancelReq) begin
      stateNext = ST_IDLE;
      finishNow = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      byteCnt   <= '0;
      opcode    <= '0;
      modeEn    <= 1'b0;
      dummyCfg  <= '0;
      addrCode  <= '0;
      modeByte  <= '0;
    end else if (regWrEn) begin
      unique case (regAddr)
        RA_ADDR:  startAddr <= regWrData;
        RA_COUNT: byteCnt   <= regWrData[CNT_W-1:0];
        RA_INSTR: begin
          opcode   <= regWrData[7:0];
          modeEn   <= regWrData[8];
          dummyCfg <= regWrData[13:9];
          addrCode <= regWrData[15:14];
        end
        RA_MODE:  modeByte  <= regWrData[7:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      addrShift <= '0;
      addrLeft  <= '0;
      dummyLeft <= '0;
      remain    <= '0;
      done      <= 1'b0;
    end else begin
      state <= stateNext;
      if (wrCtrl && regWrData[CB_DONE]) done <= 1'b0;
      if (cancelReq) done <= 1'b0;
      if (finishNow) done <= 1'b1;
      if (startReq) begin
        addrShift <= addr4 ? startAddr : {startAddr[23:0], 8'h00};
        addrLeft  <= addr4 ? 2'd3 : 2'd2;
        dummyLeft <= dummyCfg;
        remain    <= byteCnt;
        done      <= 1'b0;
      end
      if (state == ST_ADDR) begin
        addrShift <= {addrShift[23:0], 8'h00};
        if (addrLeft != '0) addrLeft <= addrLeft - 2'd1;
      end
      if (state == ST_DUMMY) dummyLeft <= dummyLeft - 5'd1;
      if (dataSlot) remain <= remain - CNT_W'(1);
    end
  end

  // flash side
  assign flashCsN    = (state == ST_IDLE);
  assign flashRead   = (state == ST_DATA);
  assign flashStrobe = (state == ST_OPC) || (state == ST_ADDR) || (state == ST_MODE) || dataSlot;

  always_comb begin
    unique case (state)
      ST_OPC:  flashTxByte = opcode;
      ST_ADDR: flashTxByte = addrShift[31:24];
      ST_MODE: flashTxByte = modeByte;
      default: flashTxByte = 8'h00;
    endcase
  end

  assign dpCtl.takeByte = dataSlot && !cancelReq;
  assign dpCtl.lastByte = (remain == CNT_W'(1));
  assign dpCtl.flush    = cancelReq;

  assign doneFlag = done;
  assign busyFlag = (state != ST_IDLE);

  // register readback
  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      RA_CTRL: begin
        regRdData[CB_BUSY] = busyFlag;
        regRdData[CB_DONE] = done;
      end
      RA_ADDR:  regRdData = startAddr;
      RA_COUNT: regRdData[CNT_W-1:0] = byteCnt;
      RA_INSTR: regRdData[15:0] = {addrCode, dummyCfg, modeEn, opcode};
      RA_MODE:  regRdData[7:0] = modeByte;
      RA_LEVEL: regRdData[LVL_W-1:0] = fifoLevel;
      default:  regRdData = '0;
    endcase
  end

endmodule

// File: rtl/flash_read_engine.sv
module flash_read_engine
  import flash_read_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        popEn,
  output logic [31:0] popData,
  output logic        flashCsN,
  output logic        flashStrobe,
  output logic        flashRead,
  output logic [7:0]  flashTxByte,
  input  logic [7:0]  flashRxByte
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  dpCtl_t           dpCtl;
  logic [LVL_W-1:0] fifoLevel;
  logic             fifoFull;
  logic             doneFlag;
  logic             busyFlag;

  flash_read_ctrl #(.CNT_W(CNT_W), .LVL_W(LVL_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .fifoFull    (fifoFull),
    .fifoLevel   (fifoLevel),
    .dpCtl       (dpCtl),
    .flashCsN    (flashCsN),
    .flashStrobe (flashStrobe),
    .flashRead   (flashRead),
    .flashTxByte (flashTxByte),
    .doneFlag    (doneFlag),
    .busyFlag    (busyFlag)
  );

  flash_read_dp #(.DEPTH(DEPTH), .LVL_W(LVL_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtl     (dpCtl),
    .rxByte    (flashRxByte),
    .popEn     (popEn),
    .popData   (popData),
    .fifoLevel (fifoLevel),
    .fifoFull  (fifoFull)
  );

endmodule

// File: rtl/flash_read_checker.sv
module flash_read_checker #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [2:0]       regAddr,
  input logic [31:0]      regWrData,
  input logic             flashCsN,
  input logic             flashStrobe,
  input logic             flashRead,
  input logic [LVL_W-1:0] fifoLevel,
  input logic             doneFlag
);

  logic ctrlWr;
  assign ctrlWr = regWrEn && (regAddr == 3'd0);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    32'(fifoLevel) <= DEPTH); // R7

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (32'(fifoLevel) <= 32'($past(fifoLevel)) + 1)); // R7

  AST_NO_SLOT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (flashStrobe && flashRead) |-> (32'(fifoLevel) < DEPTH)); // R8

  AST_SLOT_UNDER_CS: assert property (@(posedge clk) disable iff (!rstN)
    flashStrobe |-> !flashCsN); // R2

  AST_CANCEL_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWrData[1]) |=> (flashCsN && fifoLevel == '0 && !doneFlag)); // R11

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !(ctrlWr && (regWrData[5] || regWrData[1] || regWrData[0]))) |=> doneFlag); // R10

  AST_DONE_RELEASES_CS: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> flashCsN); // R10

endmodule

bind flash_read_engine flash_read_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regWrData   (regWrData),
  .flashCsN    (flashCsN),
  .flashStrobe (flashStrobe),
  .flashRead   (flashRead),
  .fifoLevel   (fifoLevel),
  .doneFlag    (doneFlag)
);

// File: tb/flash_read_engine_test.sv
module flash_read_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        popEn = 1'b0;
  logic [31:0] popData;
  logic        flashCsN, flashStrobe, flashRead;
  logic [7:0]  flashTxByte;
  logic [7:0]  flashRxByte;

  int tests = 0;
  int fails = 0;

  // flash model state
  logic [7:0] rxSeed = 8'h00;
  int         rxIdx = 0;
  logic       pendRead = 1'b0;
  assign flashRxByte = rxSeed + rxIdx[7:0];

  // scoreboard queues
  logic [7:0]  hdrQ[$];
  logic [31:0] wordQ[$];
  int          expDummy = 0;
  int          gapCnt = 0;
  logic        afterHdr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_read_engine #(.DEPTH(DEPTH), .CNT_W(16)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .popEn(popEn),
    .popData(popData), .flashCsN(flashCsN), .flashStrobe(flashStrobe),
    .flashRead(flashRead), .flashTxByte(flashTxByte), .flashRxByte(flashRxByte)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: header bytes, dummy gap, flash byte index
  initial begin
    forever begin
      @(negedge clk);
      if (pendRead) rxIdx++;
      pendRead = flashStrobe && flashRead;
      if (!flashCsN && flashStrobe && !flashRead) begin
        if (hdrQ.size() == 0) check("R2 unexpected header byte", {24'h0, flashTxByte}, 32'hFFFF_FFFF);
        else check("R2/R3 header byte", {24'h0, flashTxByte}, {24'h0, hdrQ.pop_front()});
        gapCnt = 0;
        afterHdr = 1'b1;
      end else if (!flashCsN && !flashStrobe && afterHdr) begin
        gapCnt++;
      end else if (flashStrobe && flashRead && afterHdr) begin
        check("R4 dummy gap", gapCnt, expDummy);
        afterHdr = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // driver: program registers, load expectations, start
  task automatic startRead(input logic [7:0] opc, input logic [31:0] addr, input bit addr4,
                           input bit modeOn, input logic [7:0] modeB, input int dummy,
                           input int count, input logic [7:0] seed);
    logic [31:0] w;
    writeReg(3'd1, addr);
    writeReg(3'd2, count);
    writeReg(3'd3, {16'h0, addr4 ? 2'd3 : 2'd2, 5'(dummy), modeOn, opc});
    writeReg(3'd4, {24'h0, modeB});
    hdrQ.push_back(opc);
    if (addr4) hdrQ.push_back(addr[31:24]);
    hdrQ.push_back(addr[23:16]);
    hdrQ.push_back(addr[15:8]);
    hdrQ.push_back(addr[7:0]);
    if (modeOn) hdrQ.push_back(modeB);
    w = '0;
    for (int i = 0; i < count; i++) begin
      w = w | ({24'h0, 8'(seed + 8'(i))} << (8 * (i % 4)));
      if ((i % 4) == 3 || i == count - 1) begin
        wordQ.push_back(w);
        w = '0;
      end
    end
    expDummy = dummy;
    rxSeed = seed;
    rxIdx = 0;
    writeReg(3'd0, 32'h1);
  endtask

  task automatic drain(input string tag);
    logic [31:0] lvl;
    readReg(3'd5, lvl);
    for (int i = 0; i < int'(lvl[15:0]); i++) begin
      @(negedge clk);
      popEn = 1'b1;
      #1;
      if (wordQ.size() == 0) check({tag, " extra word"}, popData, 32'hDEAD_BEEF);
      else check(tag, popData, wordQ.pop_front());
      @(posedge clk);
    end
    @(negedge clk);
    popEn = 1'b0;
  endtask

  task automatic waitDone();
    logic [31:0] c;
    for (int i = 0; i < 3000; i++) begin
      readReg(3'd0, c);
      if (c[5]) break;
    end
    check("R10 done set at end", {31'h0, c[5]}, 32'h1);
    check("R10 chip select released", {31'h0, flashCsN}, 32'h1);
  endtask

  initial begin
    logic [31:0] r;
    int got;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 chip select idle", {31'h0, flashCsN}, 32'h1);
    check("R1 no slot", {31'h0, flashStrobe}, 32'h0);
    readReg(3'd0, r); check("R1 control reads 0", r, 32'h0);
    readReg(3'd5, r); check("R1 level reads 0", r, 32'h0);

    // 3-byte address, no mode, 3 dummy cycles, 8 bytes: R2 R4 R5
    startRead(8'h0B, 32'h0012_3456, 1'b0, 1'b0, 8'h00, 3, 8, 8'h10);
    waitDone();
    readReg(3'd5, r); check("R7 level after 8 bytes", r, 32'd2);
    readReg(3'd0, r); check("R9 busy clear after finish", {31'h0, r[2]}, 32'h0);
    drain("R5 packed word");
    readReg(3'd5, r); check("R7 level after drain", r, 32'd0);
    check("R2 header fully sent", hdrQ.size(), 32'd0);

    // R10 sticky done and write-1-to-clear
    writeReg(3'd0, 32'h0);
    readReg(3'd0, r); check("R10 done sticky on write 0", {31'h0, r[5]}, 32'h1);
    writeReg(3'd0, 32'h20);
    readReg(3'd0, r); check("R10 done cleared by write 1", {31'h0, r[5]}, 32'h0);

    // 4-byte address, mode byte, no dummy, 6 bytes: R2 R3 R6
    startRead(8'hEC, 32'hA1B2_C3D4, 1'b1, 1'b1, 8'hA5, 0, 6, 8'hF0);
    waitDone();
    drain("R6 padded final word");
    check("R3 mode byte consumed", hdrQ.size(), 32'd0);
    writeReg(3'd0, 32'h20);

    // FIFO full stall: 41 bytes, no drain: R8 R9
    startRead(8'h6B, 32'h0000_0100, 1'b0, 1'b1, 8'h3C, 8, 41, 8'h40);
    repeat (150) @(negedge clk);
    got = rxIdx;
    check("R8 bytes taken before stall", got, 32'd32);
    readReg(3'd5, r); check("R7 level full", r, DEPTH);
    readReg(3'd0, r); check("R9 busy during transfer", {31'h0, r[2]}, 32'h1);
    writeReg(3'd0, 32'h1); // start while busy: no effect
    repeat (5) @(negedge clk);
    check("R9 restart ignored", rxIdx, 32'd32);
    for (int k = 0; k < 20 && wordQ.size() > 0; k++) begin
      drain("R8 word after stall");
      repeat (12) @(negedge clk);
    end
    check("R8 all words drained", wordQ.size(), 32'd0);
    waitDone();
    writeReg(3'd0, 32'h20);

    // cancel mid-transfer: R11
    startRead(8'h03, 32'h0000_2000, 1'b0, 1'b0, 8'h00, 0, 200, 8'h77);
    repeat (20) @(negedge clk);
    writeReg(3'd0, 32'h2);
    check("R11 chip select high after cancel", {31'h0, flashCsN}, 32'h1);
    readReg(3'd0, r); check("R11 busy and done clear", r, 32'h0);
    readReg(3'd5, r); check("R11 FIFO flushed", r, 32'h0);
    repeat (4) @(negedge clk);
    check("R11 no slot after cancel", {31'h0, flashStrobe}, 32'h0);
    wordQ.delete();
    hdrQ.delete();
    afterHdr = 1'b0;
    startRead(8'h03, 32'h0000_3000, 1'b0, 1'b0, 8'h00, 1, 5, 8'h01);
    waitDone();
    drain("R11 packing restarts at lane 0");
    check("R11 words after cancel", wordQ.size(), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule